// File: doc/BRIEF.md
# Auto-Sequenced SHA-1 Block Engine

This block computes SHA-1 over 512-bit message blocks through a single 32-bit data port, without any per-word addressing or explicit go command. Software writes the sixteen words of an already padded block one after another to the port. An internal word counter places each write in the block buffer, with the first write landing in the most significant word. When the sixteenth word arrives and automatic operation is enabled, compression starts by itself.

Reads from the same port return the five 32-bit digest words, most significant first. A read that arrives before the digest is valid is not acknowledged until the digest becomes valid, so software can issue the reads straight after the last write. A side-band control word, sampled with each accepted write, selects a fresh message (standard initial hash values) or a continuation block that chains from the current digest. It also enables automatic start and carries a restart strobe for the first word of a block. A two-bit status output reports engine readiness and digest validity.

The bus handshake is request/acknowledge: the master holds `bus_req` until it sees `bus_ack` for one cycle. Each acknowledged transfer takes at least two clock cycles.

Top module: `sha1_autoport`

## Requirements
- R1: Accepted writes fill the 16-word block in arrival order, with the first word as the most significant word of the block. A write carrying the restart strobe (control bit 10) is stored as word 0, so a partly written block can be abandoned and rewritten from the start.
- R2: When the write that completes word 15 is accepted with automatic mode set (control bit 11) and a mode bit set, compression starts. Ready (status bit 0) falls in the cycle after that write's acknowledge edge, while the acknowledge is high.
- R3: If the sixteenth write has automatic mode clear, or has neither mode bit set, no compression starts. Ready stays high, the digest stays valid, and reads keep returning the previous digest.
- R4: With the fresh-message bit (control bit 16) set, compression starts from the standard SHA-1 initial values. The padded block for "abc" yields a9993e36 4706816a ba3e2571 7850c26c 9cd0d89d.
- R5: With the fresh-message bit clear and the continue bit (control bit 17) set, compression chains from the current digest. The 56-character two-block test message yields f4286818 c37b27ae 0408f581 84677148 4a566572 after block one and 84983e44 1c3bd26e baae4aa1 f95129e5 e54670f1 after block two.
- R6: Successive acknowledged reads return digest words 0 to 4, most significant first. The sixth read wraps back to word 0. Starting a compression resets the read position to word 0.
- R7: A read issued while the digest is not valid receives no acknowledge until the digest becomes valid, and it then returns the new digest.
- R8: Writes accepted while the engine is busy are acknowledged but ignored. They neither change the block being compressed nor advance the word counter.
- R9: Status bit 1 is digest-valid and status bit 0 is ready. After reset the status is ready=1, valid=0. Valid is never high while ready is low.
- R10: An accepted write carrying the restart strobe while the engine is idle resets the read position to word 0.
- R11: Compression takes one round per clock for 80 rounds plus one cycle to add into the digest. Ready stays low for exactly 81 cycles, and valid rises in the same cycle that ready rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_req | input | 1 | Transfer request, held until acknowledged |
| bus_we | input | 1 | 1 = write block word, 0 = read digest word |
| bus_wdata | input | 32 | Block word to write |
| bus_ctrl | input | 32 | Side-band control: bit 10 restart strobe, bit 11 automatic mode, bit 16 fresh message, bit 17 continue message |
| bus_ack | output | 1 | One-cycle acknowledge of an accepted transfer |
| bus_rdata | output | 32 | Digest word, valid while bus_ack is high on a read |
| status | output | 2 | Bit 1 digest valid, bit 0 ready |

## Verification
The hardest situation to reach from the ports is a write that lands while the engine is busy. It must leave the running schedule intact and must also leave the word counter untouched. The bench issues three writes directly after the sixteenth word. It first checks that the digest of the running block is still correct. It then loads a complete block without any restart strobe, so the digest is correct only if the ignored writes left the counter at word 0. Read stalling is reached by issuing the first read immediately after the block completes, and the bench requires a wait of more than 80 cycles.

// File: rtl/sha1_pkg.sv
package sha1_pkg;
  localparam int WORD_W    = 32;
  localparam int BLK_WORDS = 16;
  localparam int DIG_WORDS = 5;
  localparam int ROUNDS    = 80;
  localparam int BLK_IDX_W = $clog2(BLK_WORDS);
  localparam int DIG_IDX_W = $clog2(DIG_WORDS);
  localparam int RND_W     = $clog2(ROUNDS + 1);

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [DIG_WORDS-1:0][WORD_W-1:0] dig_t;

  localparam dig_t SHA1_IV = {32'hC3D2E1F0, 32'h10325476, 32'h98BADCFE,
                              32'hEFCDAB89, 32'h67452301};

  function automatic word_t rotl(input word_t x, input int n);
    return (x << n) | (x >> (WORD_W - n));
  endfunction

  function automatic word_t round_f(input logic [RND_W-1:0] t, input word_t b,
                                    input word_t c, input word_t d);
    if (t < 20)      return (b & c) | (~b & d);
    else if (t < 40) return b ^ c ^ d;
    else if (t < 60) return (b & c) | (b & d) | (c & d);
    else             return b ^ c ^ d;
  endfunction

  function automatic word_t round_k(input logic [RND_W-1:0] t);
    if (t < 20)      return 32'h5A827999;
    else if (t < 40) return 32'h6ED9EBA1;
    else if (t < 60) return 32'h8F1BBCDC;
    else             return 32'hCA62C1D6;
  endfunction
endpackage

// File: rtl/sha1_load_seq.sv
module sha1_load_seq
  import sha1_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_ni,
  input  logic                 wr_acc,
  input  logic                 busy,
  input  logic                 strobe,
  input  logic                 auto_en,
  input  logic                 mode_init,
  input  logic                 mode_next,
  output logic                 ld_we,
  output logic [BLK_IDX_W-1:0] ld_idx,
  output logic                 start,
  output logic                 use_iv
);
  localparam logic [BLK_IDX_W-1:0] LAST = BLK_IDX_W'(BLK_WORDS - 1);

  logic [BLK_IDX_W-1:0] cnt_q, cnt_d;

  always_comb begin
    ld_we  = wr_acc & ~busy;
    ld_idx = strobe ? '0 : cnt_q;
    cnt_d  = cnt_q;
    if (ld_we) cnt_d = (ld_idx == LAST) ? '0 : ld_idx + 1'b1;
    start  = ld_we & (ld_idx == LAST) & auto_en & (mode_init | mode_next);
    use_iv = mode_init;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (ld_we) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sha1_round_core.sv
module sha1_round_core
  import sha1_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_ni,
  input  logic                 ld_we,
  input  logic [BLK_IDX_W-1:0] ld_idx,
  input  word_t                ld_data,
  input  logic                 start,
  input  logic                 use_iv,
  output logic                 busy,
  output logic                 done,
  output dig_t                 digest
);
  localparam logic [RND_W-1:0] LAST_T = RND_W'(ROUNDS);

  logic             busy_q, busy_d;
  logic [RND_W-1:0] t_q, t_d;
  dig_t             st_q, st_d, h_q, h_d;
  logic             st_en, h_en;
  word_t            sched_q [BLK_WORDS];
  logic [BLK_WORDS-1:0] sched_we;
  word_t            sched_wd;

  logic                 round_en, fin;
  logic [BLK_IDX_W-1:0] ix0, ix2, ix8, ix13;
  word_t                w_t, tmp;
  dig_t                 seed;

  always_comb begin
    round_en = busy_q && (t_q < LAST_T);
    fin      = busy_q && (t_q == LAST_T);
    ix0  = t_q[BLK_IDX_W-1:0];
    ix2  = ix0 + BLK_IDX_W'(2);
    ix8  = ix0 + BLK_IDX_W'(8);
    ix13 = ix0 + BLK_IDX_W'(13);
    w_t  = (t_q < RND_W'(BLK_WORDS)) ? sched_q[ix0]
         : rotl(sched_q[ix13] ^ sched_q[ix8] ^ sched_q[ix2] ^ sched_q[ix0], 1);
    tmp  = rotl(st_q[0], 5) + round_f(t_q, st_q[1], st_q[2], st_q[3])
         + st_q[4] + round_k(t_q) + w_t;
    seed = use_iv ? SHA1_IV : h_q;

    busy_d = busy_q;
    t_d    = t_q;
    st_d   = st_q;
    h_d    = h_q;
    st_en  = 1'b0;
    h_en   = 1'b0;
    if (start && !busy_q) begin
      busy_d = 1'b1;
      t_d    = '0;
      st_d   = seed;
      h_d    = seed;
      st_en  = 1'b1;
      h_en   = 1'b1;
    end else if (round_en) begin
      t_d   = t_q + 1'b1;
      st_d  = {st_q[3], st_q[2], rotl(st_q[1], 30), st_q[0], tmp};
      st_en = 1'b1;
    end else if (fin) begin
      busy_d = 1'b0;
      h_en   = 1'b1;
      for (int i = 0; i < DIG_WORDS; i++) h_d[i] = h_q[i] + st_q[i];
    end

    sched_wd = round_en ? w_t : ld_data;
    for (int i = 0; i < BLK_WORDS; i++)
      sched_we[i] = round_en ? (ix0 == BLK_IDX_W'(i))
                             : (ld_we && !busy_q && ld_idx == BLK_IDX_W'(i));
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      t_q    <= '0;
    end else begin
      busy_q <= busy_d;
      t_q    <= t_d;
    end
  end

  always_ff @(posedge clk) begin
    if (st_en) st_q <= st_d;
    if (h_en)  h_q  <= h_d;
  end

  for (genvar g = 0; g < BLK_WORDS; g++) begin : g_sched
    always_ff @(posedge clk) begin
      if (sched_we[g]) sched_q[g] <= sched_wd;
    end
  end

  assign busy   = busy_q;
  assign done   = fin;
  assign digest = h_q;
endmodule

// File: rtl/sha1_read_seq.sv
module sha1_read_seq
  import sha1_pkg::*;
(
  input  logic  clk,
  input  logic  rst_ni,
  input  logic  rd_acc,
  input  logic  clear,
  input  dig_t  digest,
  output word_t rdata
);
  localparam logic [DIG_IDX_W-1:0] LAST = DIG_IDX_W'(DIG_WORDS - 1);

  logic [DIG_IDX_W-1:0] cnt_q, cnt_d;
  logic                 cnt_en;
  word_t                rdata_q;

  always_comb begin
    cnt_en = clear | rd_acc;
    if (clear)               cnt_d = '0;
    else if (cnt_q == LAST)  cnt_d = '0;
    else                     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk) begin
    if (rd_acc) rdata_q <= digest[cnt_q];
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/sha1_autoport.sv
module sha1_autoport
  import sha1_pkg::*;
#(
  parameter int CTRL_W    = 32,
  parameter int STRB_BIT  = 10,
  parameter int AUTO_BIT  = 11,
  parameter int INIT_BIT  = 16,
  parameter int NEXT_BIT  = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  input  logic [CTRL_W-1:0] bus_ctrl,
  output logic              bus_ack,
  output logic [31:0]       bus_rdata,
  output logic [1:0]        status
);
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  logic                 ack_q, ack_d, valid_q, valid_d;
  logic                 accept, wr_acc, rd_acc, rd_clr;
  logic                 busy, done, start, use_iv, ld_we;
  logic [BLK_IDX_W-1:0] ld_idx;
  dig_t                 digest;
  logic                 unused_ctrl;

  assign unused_ctrl = ^bus_ctrl;

  always_comb begin
    accept  = bus_req & ~ack_q;
    wr_acc  = accept & bus_we;
    rd_acc  = accept & ~bus_we & valid_q;
    ack_d   = wr_acc | rd_acc;
    rd_clr  = start | (wr_acc & ~busy & bus_ctrl[STRB_BIT]);
    valid_d = valid_q;
    if (start)     valid_d = 1'b0;
    else if (done) valid_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q   <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      ack_q   <= ack_d;
      valid_q <= valid_d;
    end
  end

  sha1_load_seq u_load (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .wr_acc    (wr_acc),
    .busy      (busy),
    .strobe    (bus_ctrl[STRB_BIT]),
    .auto_en   (bus_ctrl[AUTO_BIT]),
    .mode_init (bus_ctrl[INIT_BIT]),
    .mode_next (bus_ctrl[NEXT_BIT]),
    .ld_we     (ld_we),
    .ld_idx    (ld_idx),
    .start     (start),
    .use_iv    (use_iv)
  );

  sha1_round_core u_core (
    .clk     (clk),
    .rst_ni  (rst_ni),
    .ld_we   (ld_we),
    .ld_idx  (ld_idx),
    .ld_data (bus_wdata),
    .start   (start),
    .use_iv  (use_iv),
    .busy    (busy),
    .done    (done),
    .digest  (digest)
  );

  sha1_read_seq u_read (
    .clk    (clk),
    .rst_ni (rst_ni),
    .rd_acc (rd_acc),
    .clear  (rd_clr),
    .digest (digest),
    .rdata  (bus_rdata)
  );

  assign bus_ack = ack_q;
  assign status  = {valid_q, ~busy};
endmodule

// File: rtl/sha1_autoport_chk.sv
module sha1_autoport_chk
  import sha1_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       bus_req,
  input logic       bus_we,
  input logic       bus_ack,
  input logic [1:0] status
);
  localparam logic [7:0] BUSY_CYC = 8'(ROUNDS + 1);

  logic [7:0] low_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         low_cnt_q <= '0;
    else if (!status[0]) low_cnt_q <= low_cnt_q + 1'b1;
    else                low_cnt_q <= '0;
  end

  // R2
  auto_start_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[0]) |-> bus_ack);

  // R7
  read_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we && !bus_ack && !status[1]) |=> !bus_ack);

  // R9
  valid_implies_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status[1] |-> status[0]);

  // R11
  busy_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[0]) |-> (low_cnt_q == BUSY_CYC));

  // R11
  valid_with_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[1]) |-> $rose(status[0]));

  // R7
  single_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack |=> !bus_ack);
endmodule

bind sha1_autoport sha1_autoport_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .bus_req (bus_req),
  .bus_we  (bus_we),
  .bus_ack (bus_ack),
  .status  (status)
);

// File: tb/sim_sha1_autoport.sv
`timescale 1ns/1ps
module sim_sha1_autoport;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_ctrl = '0;
  logic        bus_ack;
  logic [31:0] bus_rdata;
  logic [1:0]  status;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  localparam logic [31:0] C_STRB = 32'h0000_0400;
  localparam logic [31:0] C_AUTO = 32'h0000_0800;
  localparam logic [31:0] C_INIT = 32'h0001_0000;
  localparam logic [31:0] C_NEXT = 32'h0002_0000;

  logic [31:0] blk [16];
  logic [31:0] exp_d [5];

  always #4 clk = ~clk;

  sha1_autoport u0 (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_ctrl(bus_ctrl), .bus_ack(bus_ack),
    .bus_rdata(bus_rdata), .status(status)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [31:0] d, input logic [31:0] c);
    bus_req = 1'b1; bus_we = 1'b1; bus_wdata = d; bus_ctrl = c;
    @(negedge clk);
    while (!bus_ack) @(negedge clk);
    bus_req = 1'b0;
  endtask

  task automatic bus_read(output logic [31:0] d, output int waited);
    waited = 0;
    bus_req = 1'b1; bus_we = 1'b0;
    @(negedge clk);
    while (!bus_ack) begin waited++; @(negedge clk); end
    d = bus_rdata;
    bus_req = 1'b0;
  endtask

  task automatic load_abc();
    for (int i = 0; i < 16; i++) blk[i] = 32'h0;
    blk[0] = 32'h61626380; blk[15] = 32'h00000018;
    exp_d = '{32'ha9993e36, 32'h4706816a, 32'hba3e2571, 32'h7850c26c, 32'h9cd0d89d};
  endtask

  task automatic send_block(input logic [31:0] mode, input bit use_strobe);
    for (int i = 0; i < 16; i++)
      bus_write(blk[i], mode | ((i == 0 && use_strobe) ? C_STRB : 32'h0));
  endtask

  task automatic read_digest(input string req);
    logic [31:0] d;
    int w;
    for (int i = 0; i < 5; i++) begin
      bus_read(d, w);
      chk(req, d, exp_d[i]);
    end
  endtask

  task automatic t_reset();
    chk("R9 reset status", {30'h0, status}, 32'h1);
    chk("R9 reset ack", {31'h0, bus_ack}, 32'h0);
  endtask

  task automatic t_abc_init();
    int low;
    load_abc();
    send_block(C_AUTO | C_INIT, 1'b1);
    chk("R2 ready low after 16th write", {31'h0, status[0]}, 32'h0);
    low = 0;
    while (!status[0]) begin low++; @(negedge clk); end
    chk("R11 busy cycles", low, 81);
    chk("R11 valid with ready", {30'h0, status}, 32'h3);
    read_digest("R4 abc digest");
    begin
      logic [31:0] d; int w;
      bus_read(d, w);
      chk("R6 sixth read wraps", d, 32'ha9993e36);
    end
  endtask

  task automatic t_strobe_read_clear();
    logic [31:0] d; int w;
    bus_read(d, w);
    chk("R6 second word after wrap", d, 32'h4706816a);
    bus_write(32'h12345678, C_STRB);
    bus_read(d, w);
    chk("R10 strobe resets read position", d, 32'ha9993e36);
  endtask

  task automatic t_restart_two_block();
    for (int i = 0; i < 4; i++) bus_write(32'hdead0000 + i, C_AUTO | C_INIT);
    chk("R1 partial block does not start", {30'h0, status}, 32'h3);
    blk = '{32'h61626364, 32'h62636465, 32'h63646566, 32'h64656667,
            32'h65666768, 32'h66676869, 32'h6768696A, 32'h68696A6B,
            32'h696A6B6C, 32'h6A6B6C6D, 32'h6B6C6D6E, 32'h6C6D6E6F,
            32'h6D6E6F70, 32'h6E6F7071, 32'h80000000, 32'h00000000};
    exp_d = '{32'hf4286818, 32'hc37b27ae, 32'h0408f581, 32'h84677148, 32'h4a566572};
    send_block(C_AUTO | C_INIT, 1'b1);
    read_digest("R1 R5 restarted first block");
    for (int i = 0; i < 16; i++) blk[i] = 32'h0;
    blk[15] = 32'h000001c0;
    exp_d = '{32'h84983e44, 32'h1c3bd26e, 32'hbaae4aa1, 32'hf95129e5, 32'he54670f1};
    send_block(C_AUTO | C_NEXT, 1'b1);
    read_digest("R5 chained second block");
  endtask

  task automatic t_no_auto();
    bit dropped = 1'b0;
    for (int i = 0; i < 16; i++) begin
      bus_write(32'h0f0f0000 + i, (i == 0) ? (C_STRB | C_INIT) : C_INIT);
      if (status != 2'b11) dropped = 1'b1;
    end
    @(negedge clk);
    chk("R3 auto clear keeps ready", {31'h0, dropped}, 32'h0);
    for (int i = 0; i < 16; i++) begin
      bus_write(32'h0e0e0000 + i, (i == 0) ? (C_STRB | C_AUTO) : C_AUTO);
      if (status != 2'b11) dropped = 1'b1;
    end
    @(negedge clk);
    chk("R3 no mode bit keeps ready", {31'h0, dropped}, 32'h0);
    read_digest("R3 previous digest kept");
  endtask

  task automatic t_read_stall();
    logic [31:0] d; int w;
    load_abc();
    send_block(C_AUTO | C_INIT, 1'b1);
    bus_read(d, w);
    chk("R7 early read stalled", {31'h0, (w > 80)}, 32'h1);
    chk("R7 stalled read data", d, 32'ha9993e36);
    bus_read(d, w);
    chk("R6 next word after stall", d, 32'h4706816a);
  endtask

  task automatic t_busy_writes();
    load_abc();
    send_block(C_AUTO | C_INIT, 1'b1);
    for (int i = 0; i < 3; i++) bus_write(32'hffffffff, C_AUTO | C_INIT | C_STRB);
    chk("R8 busy writes acked while busy", {31'h0, status[0]}, 32'h0);
    read_digest("R8 running block intact");
    send_block(C_AUTO | C_INIT, 1'b0);
    read_digest("R8 counter not advanced");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_abc_init();
    t_strobe_read_clear();
    t_restart_two_block();
    t_no_auto();
    t_read_stall();
    t_busy_writes();
    if (!finished) begin
      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule